// File: doc/BRIEF.md
# Port Mode Option Register and Strobe Pin Multiplexer

This block holds a byte-wide option register on the special-function-register (SFR) bus of a small 8-bit controller and turns its bits into pad controls. One bit picks open-drain or weak pull-up behaviour for the eight pins of the main bidirectional port. Four bits each give one of the upper four pins of a second port a high sink-current drive. Two bits hand the address-latch strobe pin and the program-fetch strobe pin over to general-purpose use. These two pins then become bits 5 and 6 of a seven-bit auxiliary port, which has its own latch register on the same bus.

The block also generates the address-latch strobe from a machine-cycle state index. A machine cycle has six states, numbered 0 to 5. The strobe pulses in states 0 and 3. It keeps pulsing until software either moves the pin to general-purpose use or the quiet input, which comes from a separate auxiliary control register, is raised. While the pin is still in strobe mode and quiet is high, the strobe is held low. The program-fetch strobe comes from the core and passes through unchanged until its pin is switched to general-purpose use.

Each pad has three controls. `oe` turns on the strong driver. `do` is the value that driver puts out. `pu` turns on a weak pull-up. A pin in quasi-bidirectional mode drives low when its latch bit is 0 and applies the weak pull-up when its latch bit is 1.

Top module: `pin_option_mux`

## Requirements
- R1: After reset the option register reads 0x00 and the auxiliary latch holds 1 in bits 0-3, 5 and 6. The main port is therefore open-drain with no pull-up, no pin has high drive, the address-latch strobe pulses, and the fetch strobe passes through.
- R2: The option register sits at SFR address 0x86. Its bits are: bit 7 moves the fetch-strobe pin to I/O, bit 6 moves the address-latch pin to I/O, bit 5 is unused, bits 4..1 give high drive to port pins 7..4 in that order, and bit 0 enables the main-port pull-up. Bit 5 ignores writes and reads 0; every other bit reads back as it was written.
- R3: For each main-port pin, `p0_oe` is the inverse of its latch bit. `p0_pu` equals the latch bit when option bit 0 is set, and is 0 when option bit 0 is clear.
- R4: `p3_hd[k]`, which drives port pin 4+k, equals option bit k+1 from the clock edge that writes it.
- R5: While the address-latch pin is in strobe mode and quiet is low, `aux_do[5]` is 1 in the cycle after `mc_state` is 0 or 3, and 0 after states 1, 2, 4 and 5. `aux_oe[5]` is 1 and `aux_pu[5]` is 0 throughout.
- R6: While the address-latch pin is in strobe mode and quiet is high, `aux_do[5]` is held at 0 in every state, with `aux_oe[5]` still at 1.
- R7: With option bit 6 set, pin 5 is quasi-bidirectional from auxiliary latch bit 5: `do` is 0, `oe` is the inverse of the latch bit, and `pu` equals the latch bit. This holds whatever the level of quiet.
- R8: With option bit 7 clear, `aux_do[6]` follows `core_psen_n`, with `oe` 1 and `pu` 0. With option bit 7 set, pin 6 is quasi-bidirectional from auxiliary latch bit 6.
- R9: The auxiliary latch is written at SFR address 0xD8, and only bits 0-3, 5 and 6 are stored. Reading that address returns the `aux_pin` levels in bits 0-3, 5 and 6, and 0 in bits 4 and 7.
- R10: Auxiliary pins 0-3 are always quasi-bidirectional from their latch bits. Pin 4 has `oe`, `pu` and `do` all at 0.
- R11: Writes to any address other than 0x86 and 0xD8 change no state. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data for sfr_addr |
| mc_state | input | 3 | Machine-cycle state index, 0 to 5 |
| ale_quiet | input | 1 | Silences the address-latch strobe while its pin is in strobe mode |
| core_psen_n | input | 1 | Program-fetch strobe from the core |
| p0_latch | input | 8 | Main-port output latch |
| p0_oe | output | 8 | Main-port pull-low enable per pin |
| p0_pu | output | 8 | Main-port weak pull-up enable per pin |
| p3_hd | output | 4 | High-drive enable for port pins 4..7 |
| aux_pin | input | 7 | Auxiliary pad input levels |
| aux_do | output | 7 | Auxiliary pad drive value |
| aux_oe | output | 7 | Auxiliary pad strong-drive enable |
| aux_pu | output | 7 | Auxiliary pad weak pull-up enable |

## Verification
The bench writes all 256 option values and all 256 auxiliary-latch values, and sweeps every main-port latch pattern with the pull-up both off and on. This catches a bit-order slip in the high-drive field, which would light the wrong LED pin, and a writable unused bit, which would read back as 1. The strobe is walked through all six states with quiet low and high and with the pin in both modes. A design that keyed quiet on the wrong bit would keep pulsing a pin the software had silenced. A design that let quiet override I/O mode would ground a general-purpose output. Reads of the auxiliary address with bit 4 driven prove that pin levels are returned and that absent bits read 0.

// File: rtl/pinopt_pkg.sv
package pinopt_pkg;
  localparam int SFR_W   = 8;
  localparam int AUX_W   = 7;
  localparam int P0_W    = 8;
  localparam int HD_W    = 4;
  localparam int ALE_BIT  = 5;
  localparam int PSEN_BIT = 6;

  localparam logic [SFR_W-1:0] OPT_WMASK = 8'hDF;
  localparam logic [AUX_W-1:0] AUX_MASK  = 7'b110_1111;

  typedef struct packed {
    logic            psen_io;
    logic            ale_io;
    logic            rsvd;
    logic [HD_W-1:0] hi_drive;
    logic            p0_pull;
  } opt_t;
endpackage

// File: rtl/pinopt_regs.sv
module pinopt_regs
  import pinopt_pkg::*;
#(
  parameter logic [SFR_W-1:0] OPT_ADDR = 8'h86,
  parameter logic [SFR_W-1:0] AUX_ADDR = 8'hD8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SFR_W-1:0] sfr_addr,
  input  logic [SFR_W-1:0] sfr_wdata,
  input  logic             sfr_wr,
  input  logic [AUX_W-1:0] aux_pin,
  output logic [SFR_W-1:0] sfr_rdata,
  output opt_t             opt_q,
  output logic [AUX_W-1:0] aux_latch_q
);
  logic             opt_en;
  logic             aux_en;
  opt_t             opt_n;
  logic [AUX_W-1:0] aux_n;

  always_comb begin
    opt_en = sfr_wr && (sfr_addr == OPT_ADDR);
    aux_en = sfr_wr && (sfr_addr == AUX_ADDR);
    opt_n  = opt_t'(sfr_wdata & OPT_WMASK);
    aux_n  = sfr_wdata[AUX_W-1:0] & AUX_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opt_q <= '0;
    else if (opt_en) opt_q <= opt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_latch_q <= AUX_MASK;
    else if (aux_en) aux_latch_q <= aux_n;
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == OPT_ADDR)      sfr_rdata = opt_q;
    else if (sfr_addr == AUX_ADDR) sfr_rdata = {1'b0, aux_pin & AUX_MASK};
  end
endmodule

// File: rtl/pinopt_ale_gen.sv
module pinopt_ale_gen #(
  parameter int STATE_W = 3,
  parameter int PULSE_A = 0,
  parameter int PULSE_B = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] mc_state,
  input  logic               ale_quiet,
  output logic               ale_o
);
  localparam logic [STATE_W-1:0] ST_A = STATE_W'(PULSE_A);
  localparam logic [STATE_W-1:0] ST_B = STATE_W'(PULSE_B);

  logic ale_n;

  always_comb begin
    ale_n = !ale_quiet && ((mc_state == ST_A) || (mc_state == ST_B));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ale_o <= 1'b0;
    else        ale_o <= ale_n;
  end
endmodule

// File: rtl/pinopt_pad_mux.sv
module pinopt_pad_mux
  import pinopt_pkg::*;
(
  input  opt_t             opt,
  input  logic [AUX_W-1:0] aux_latch,
  input  logic             ale_sig,
  input  logic             psen_sig,
  input  logic [P0_W-1:0]  p0_latch,
  output logic [P0_W-1:0]  p0_oe,
  output logic [P0_W-1:0]  p0_pu,
  output logic [HD_W-1:0]  p3_hd,
  output logic [AUX_W-1:0] aux_do,
  output logic [AUX_W-1:0] aux_oe,
  output logic [AUX_W-1:0] aux_pu
);
  always_comb begin
    p0_oe = ~p0_latch;
    p0_pu = p0_latch & {P0_W{opt.p0_pull}};
    p3_hd = opt.hi_drive;

    aux_do = '0;
    aux_oe = ~aux_latch & AUX_MASK;
    aux_pu =  aux_latch & AUX_MASK;

    if (!opt.ale_io) begin
      aux_do[ALE_BIT] = ale_sig;
      aux_oe[ALE_BIT] = 1'b1;
      aux_pu[ALE_BIT] = 1'b0;
    end
    if (!opt.psen_io) begin
      aux_do[PSEN_BIT] = psen_sig;
      aux_oe[PSEN_BIT] = 1'b1;
      aux_pu[PSEN_BIT] = 1'b0;
    end
  end
endmodule

// File: rtl/pin_option_mux.sv
module pin_option_mux
  import pinopt_pkg::*;
#(
  parameter logic [7:0] OPT_ADDR = 8'h86,
  parameter logic [7:0] AUX_ADDR = 8'hD8,
  parameter int         STATE_W  = 3,
  parameter int         PULSE_A  = 0,
  parameter int         PULSE_B  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         sfr_addr,
  input  logic [7:0]         sfr_wdata,
  input  logic               sfr_wr,
  output logic [7:0]         sfr_rdata,
  input  logic [STATE_W-1:0] mc_state,
  input  logic               ale_quiet,
  input  logic               core_psen_n,
  input  logic [7:0]         p0_latch,
  output logic [7:0]         p0_oe,
  output logic [7:0]         p0_pu,
  output logic [3:0]         p3_hd,
  input  logic [6:0]         aux_pin,
  output logic [6:0]         aux_do,
  output logic [6:0]         aux_oe,
  output logic [6:0]         aux_pu
);
  opt_t             opt_q;
  logic [AUX_W-1:0] aux_latch;
  logic             ale_sig;

  pinopt_regs #(.OPT_ADDR(OPT_ADDR), .AUX_ADDR(AUX_ADDR)) i_regs (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .aux_pin(aux_pin), .sfr_rdata(sfr_rdata),
    .opt_q(opt_q), .aux_latch_q(aux_latch)
  );

  pinopt_ale_gen #(.STATE_W(STATE_W), .PULSE_A(PULSE_A), .PULSE_B(PULSE_B)) i_ale (
    .clk(clk), .rst_n(rst_n), .mc_state(mc_state), .ale_quiet(ale_quiet),
    .ale_o(ale_sig)
  );

  pinopt_pad_mux i_mux (
    .opt(opt_q), .aux_latch(aux_latch), .ale_sig(ale_sig), .psen_sig(core_psen_n),
    .p0_latch(p0_latch), .p0_oe(p0_oe), .p0_pu(p0_pu), .p3_hd(p3_hd),
    .aux_do(aux_do), .aux_oe(aux_oe), .aux_pu(aux_pu)
  );
endmodule

// File: rtl/pinopt_chk.sv
module pinopt_chk
  import pinopt_pkg::*;
#(
  parameter logic [7:0] OPT_ADDR = 8'h86,
  parameter int         STATE_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         sfr_addr,
  input logic [7:0]         sfr_wdata,
  input logic               sfr_wr,
  input logic [7:0]         sfr_rdata,
  input logic [STATE_W-1:0] mc_state,
  input logic               ale_quiet,
  input opt_t               opt_q,
  input logic [7:0]         p0_pu,
  input logic [3:0]         p3_hd,
  input logic [6:0]         aux_do
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == OPT_ADDR) |-> !sfr_rdata[5]);

  p_p0_open_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_q.p0_pull |-> (p0_pu == '0));

  p_hd_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == OPT_ADDR) |=> (p3_hd == $past(sfr_wdata[4:1])));

  p_ale_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_quiet && !opt_q.ale_io && mc_state == '0) |=> (opt_q.ale_io || aux_do[ALE_BIT]));

  p_ale_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_quiet && !opt_q.ale_io) |=> (opt_q.ale_io || !aux_do[ALE_BIT]));

  p_psen_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opt_q.psen_io |-> !aux_do[PSEN_BIT]);
endmodule

bind pin_option_mux pinopt_chk #(.OPT_ADDR(OPT_ADDR), .STATE_W(STATE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
  .sfr_wr(sfr_wr), .sfr_rdata(sfr_rdata), .mc_state(mc_state),
  .ale_quiet(ale_quiet), .opt_q(opt_q), .p0_pu(p0_pu), .p3_hd(p3_hd),
  .aux_do(aux_do)
);

// File: tb/test_pin_option_mux.sv
module test_pin_option_mux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_wr;
  logic [2:0] mc_state;
  logic       ale_quiet, core_psen_n;
  logic [7:0] p0_latch, p0_oe, p0_pu;
  logic [3:0] p3_hd;
  logic [6:0] aux_pin, aux_do, aux_oe, aux_pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_option_mux i_pin_option_mux (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rdata(sfr_rdata), .mc_state(mc_state),
    .ale_quiet(ale_quiet), .core_psen_n(core_psen_n), .p0_latch(p0_latch),
    .p0_oe(p0_oe), .p0_pu(p0_pu), .p3_hd(p3_hd), .aux_pin(aux_pin),
    .aux_do(aux_do), .aux_oe(aux_oe), .aux_pu(aux_pu)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  // quasi-bidirectional expectation for one aux pin
  task automatic chk_quasi(input int b, input bit lat, input string req);
    chk(aux_do[b] == 1'b0 && aux_oe[b] == !lat && aux_pu[b] == lat, req,
        {aux_do[b], aux_oe[b], aux_pu[b]}, {1'b0, !lat, lat});
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00; sfr_wr = 1'b0;
    mc_state = 3'd1; ale_quiet = 1'b0; core_psen_n = 1'b1;
    p0_latch = 8'hFF; aux_pin = 7'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(8'h86, rv);
    chk(rv == 8'h00, "R1 option reset", rv, 0);
    chk(p0_pu == 8'h00 && p3_hd == 4'h0, "R1 port defaults", {p0_pu, p3_hd}, 0);
    for (int b = 0; b < 4; b++) chk_quasi(b, 1'b1, "R1 aux latch reset");
    chk(aux_do[6] == 1'b1 && aux_oe[6], "R1 fetch strobe passes", aux_do[6], 1);
    core_psen_n = 1'b0; #1;
    chk(aux_do[6] == 1'b0, "R1 fetch strobe passes low", aux_do[6], 0);
    @(negedge clk); mc_state = 3'd0; @(negedge clk); #1;
    chk(aux_do[5] == 1'b1, "R1 strobe pulses after reset", aux_do[5], 1);

    // R2 R4 R3 R8: sweep all option values
    p0_latch = 8'hA5;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      wr(8'h86, vb);
      rd(8'h86, rv);
      chk(rv == (vb & 8'hDF), "R2 option readback", rv, vb & 8'hDF);
      chk(p3_hd == vb[4:1], "R4 high drive map", p3_hd, vb[4:1]);
      chk(p0_pu == (8'hA5 & {8{vb[0]}}), "R3 pull-up", p0_pu, 8'hA5 & {8{vb[0]}});
      chk(p0_oe == 8'h5A, "R3 pull-low", p0_oe, 8'h5A);
      if (vb[7]) chk_quasi(6, 1'b1, "R8 fetch pin as io");
      else chk(aux_do[6] == core_psen_n && aux_oe[6] && !aux_pu[6],
               "R8 fetch pin as strobe", aux_do[6], core_psen_n);
    end

    // R3 full latch sweep
    for (int pl = 0; pl < 2; pl++) begin
      wr(8'h86, 8'(pl));
      for (int l = 0; l < 256; l++) begin
        p0_latch = 8'(l); #1;
        chk(p0_oe == ~8'(l) && p0_pu == (8'(l) & {8{pl[0]}}), "R3 port sweep",
            {p0_oe, p0_pu}, {~8'(l), 8'(l) & {8{pl[0]}}});
      end
    end

    // R5 R6 R7 strobe pin
    for (int io = 0; io < 2; io++) begin
      wr(8'h86, io[0] ? 8'h40 : 8'h00);
      for (int q = 0; q < 2; q++) begin
        for (int s = 0; s < 6; s++) begin
          @(negedge clk);
          ale_quiet = q[0]; mc_state = 3'(s);
          @(negedge clk); #1;
          if (io[0]) chk_quasi(5, 1'b1, "R7 strobe pin as io");
          else if (q[0]) chk(aux_do[5] == 1'b0 && aux_oe[5], "R6 quiet holds low", aux_do[5], 0);
          else chk(aux_do[5] == (s == 0 || s == 3) && aux_oe[5] && !aux_pu[5],
                   "R5 strobe timing", aux_do[5], (s == 0 || s == 3));
        end
      end
    end
    ale_quiet = 1'b0;

    // R9 R10 R7 R8 aux latch sweep with both strobe pins as io
    wr(8'h86, 8'hC0);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      wr(8'hD8, vb);
      for (int b = 0; b < 4; b++) chk_quasi(b, vb[b], "R10 low aux pins");
      chk(aux_oe[4] == 0 && aux_pu[4] == 0 && aux_do[4] == 0, "R10 absent pin", aux_oe[4], 0);
      chk_quasi(5, vb[5], "R7 strobe io latch");
      chk_quasi(6, vb[6], "R8 fetch io latch");
    end
    for (int p = 0; p < 128; p++) begin
      aux_pin = 7'(p);
      rd(8'hD8, rv);
      chk(rv == (8'(p) & 8'h6F), "R9 aux read pins", rv, 8'(p) & 8'h6F);
    end

    // R11 stray addresses
    wr(8'h86, 8'h15);
    wr(8'hD8, 8'h00);
    wr(8'h87, 8'hFF);
    wr(8'hD9, 8'hFF);
    wr(8'h06, 8'hFF);
    rd(8'h86, rv);
    chk(rv == 8'h15, "R11 option untouched", rv, 8'h15);
    for (int b = 0; b < 4; b++) chk_quasi(b, 1'b0, "R11 aux untouched");
    rd(8'h87, rv);
    chk(rv == 8'h00, "R11 stray read", rv, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule